// File: doc/BRIEF.md
# High-Half Byte Insert / Extract / Mask Unit

This unit computes the high-half byte-manipulation operations of a 64-bit integer instruction group. There are three kinds: insert-high, extract-high and mask-high. Each comes in word (16-bit), longword (32-bit) and quadword (64-bit) sizes.

Each operation takes a source operand A and a byte offset from the low three bits of operand B. A 7-bit function code picks the operation. When the code is not one this unit handles, the current destination value passes through unchanged.

The result is available combinationally in the same cycle. A valid-qualified register stage, chosen by parameter, also presents it one cycle later for callers that need a registered output.

Top module: `bytelane_hi_unit`

## Requirements
- R1: Function code 0x57 performs word insert-high and 0x5A performs word extract-high; the operand size is 16 bits.
- R2: Function code 0x67 performs longword insert-high and 0x6A performs longword extract-high; the operand size is 32 bits.
- R3: Function code 0x77 performs quadword insert-high and 0x7A performs quadword extract-high; the operand size is 64 bits.
- R4: The insert/extract shift count is (64 - 8*B[2:0]) mod 64, so a zero offset gives a zero shift. Bits B[63:3] have no effect on any result.
- R5: Insert-high keeps only the low operand-size bits of A, then shifts that value right by the shift count.
- R6: Extract-high shifts A left by the shift count, then keeps only the low operand-size bits. All result bits above the operand size are zero.
- R7: Mask-high uses codes 0x52 (word, select base 0x03), 0x62 (longword, base 0x0F) and 0x72 (quadword, base 0xFF). The select mask is the base shifted right by 8 - B[2:0]. Result byte i, which is bits 8i+7..8i, is zero when select bit i is set; otherwise it equals byte i of A.
- R8: A mask-high with byte offset 0 returns A unchanged.
- R9: Any other function code returns the destination input unchanged.
- R10: `res_comb` reflects the current inputs in the same cycle, with no register in the path.
- R11: With OUT_REG=1, a cycle with `in_valid` high loads that cycle's result into `out_res` and raises `out_valid` on the next cycle. A cycle with `in_valid` low clears `out_valid` and leaves `out_res` unchanged.
- R12: While `rst_n` is low, `out_valid` and `out_res` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the inputs for capture |
| func | input | 7 | Function code |
| opa | input | 64 | Source operand A |
| opb | input | 64 | Operand B; bits 2..0 are the byte offset |
| dst_in | input | 64 | Current destination value |
| res_comb | output | 64 | Combinational result |
| out_valid | output | 1 | Registered result valid |
| out_res | output | 64 | Registered result |

## Verification
The assertions check the following on every cycle:
- the pass-through of the destination value for unhandled codes;
- the zero upper bits of extract results;
- that mask-high only ever clears bits of A;
- the identity cases at offset zero;
- the valid and hold behaviour of the output register.

Exact values for each code and offset can only be shown by the bench's sweep. It covers all nine codes at all eight offsets over several data patterns, with B's upper bits set, and compares against an arithmetic model. The sweep is also what catches a swapped insert/extract code pairing.

// File: rtl/bytelane_hi_unit.sv
module bytelane_hi_unit #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [6:0]  func,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic [63:0] dst_in,
  output logic [63:0] res_comb,
  output logic        out_valid,
  output logic [63:0] out_res
);

  localparam logic [6:0] F_MSK_W = 7'h52, F_INS_W = 7'h57, F_EXT_W = 7'h5A;
  localparam logic [6:0] F_MSK_L = 7'h62, F_INS_L = 7'h67, F_EXT_L = 7'h6A;
  localparam logic [6:0] F_MSK_Q = 7'h72, F_INS_Q = 7'h77, F_EXT_Q = 7'h7A;
  localparam logic [63:0] M16 = 64'h0000_0000_0000_FFFF;
  localparam logic [63:0] M32 = 64'h0000_0000_FFFF_FFFF;

  logic [2:0] off;
  logic [2:0] neg_off;
  logic [5:0] sc;
  logic [3:0] msc;
  logic [7:0] sel_w, sel_l, sel_q;
  logic       unused_opb_hi;

  assign off     = opb[2:0];
  assign neg_off = 3'd0 - off;
  assign sc      = {neg_off, 3'b000};
  assign msc     = 4'd8 - {1'b0, off};
  assign sel_w   = 8'h03 >> msc;
  assign sel_l   = 8'h0F >> msc;
  assign sel_q   = 8'hFF >> msc;
  assign unused_opb_hi = ^opb[63:3];

  function automatic logic [63:0] clear_bytes(input logic [63:0] v, input logic [7:0] sel);
    logic [63:0] r;
    r = v;
    for (int i = 0; i < 8; i++)
      if (sel[i]) r[8*i +: 8] = 8'h00;
    return r;
  endfunction

  always_comb begin
    case (func)
      F_MSK_W: res_comb = clear_bytes(opa, sel_w);
      F_INS_W: res_comb = (opa & M16) >> sc;
      F_EXT_W: res_comb = (opa << sc) & M16;
      F_MSK_L: res_comb = clear_bytes(opa, sel_l);
      F_INS_L: res_comb = (opa & M32) >> sc;
      F_EXT_L: res_comb = (opa << sc) & M32;
      F_MSK_Q: res_comb = clear_bytes(opa, sel_q);
      F_INS_Q: res_comb = opa >> sc;
      F_EXT_Q: res_comb = opa << sc;
      default: res_comb = dst_in;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          out_res   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_res <= res_comb;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_res   = res_comb;
    end
  endgenerate

endmodule

// File: rtl/bytelane_hi_chk.sv
module bytelane_hi_chk #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [6:0]  func,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic [63:0] dst_in,
  input logic [63:0] res_comb,
  input logic        out_valid,
  input logic [63:0] out_res
);

  logic known;
  assign known = (func == 7'h52) || (func == 7'h57) || (func == 7'h5A) ||
                 (func == 7'h62) || (func == 7'h67) || (func == 7'h6A) ||
                 (func == 7'h72) || (func == 7'h77) || (func == 7'h7A);

  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> res_comb == dst_in);

  a_r6_ext_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 7'h5A) |-> res_comb[63:16] == 48'h0);

  a_r6_extl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 7'h6A) |-> res_comb[63:32] == 32'h0);

  a_r7_mask_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (func == 7'h52 || func == 7'h62 || func == 7'h72) |-> (res_comb & ~opa) == 64'h0);

  a_r8_mask_off0: assert property (@(posedge clk) disable iff (!rst_n)
    ((func == 7'h52 || func == 7'h62 || func == 7'h72) && opb[2:0] == 3'd0) |-> res_comb == opa);

  a_r4_quad_off0: assert property (@(posedge clk) disable iff (!rst_n)
    ((func == 7'h77 || func == 7'h7A) && opb[2:0] == 3'd0) |-> res_comb == opa);

  generate
    if (OUT_REG) begin : g_reg_chk
      a_r11_capture: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid && out_res == $past(res_comb));
      a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_res));
    end
  endgenerate

  always_comb begin
    if (!rst_n && OUT_REG)
      a_r12_reset: assert (out_valid == 1'b0 && out_res == 64'h0);
  end

endmodule

bind bytelane_hi_unit bytelane_hi_chk #(.OUT_REG(OUT_REG)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func), .opa(opa),
  .opb(opb), .dst_in(dst_in), .res_comb(res_comb), .out_valid(out_valid),
  .out_res(out_res)
);

// File: tb/bytelane_hi_unit_tb.sv
module bytelane_hi_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [6:0]  func = 7'h0;
  logic [63:0] opa = '0, opb = '0, dst_in = '0;
  logic [63:0] res_comb, out_res;
  logic        out_valid;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bytelane_hi_unit #(.OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func(func), .opa(opa),
    .opb(opb), .dst_in(dst_in), .res_comb(res_comb), .out_valid(out_valid),
    .out_res(out_res)
  );

  function automatic logic [63:0] model(input logic [6:0] f, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] d);
    int o, nb, s;
    logic [63:0] keep, r;
    o = int'(b[2:0]);
    s = (o == 0) ? 0 : 64 - 8 * o;
    case (f)
      7'h52, 7'h57, 7'h5A: nb = 2;
      7'h62, 7'h67, 7'h6A: nb = 4;
      default:             nb = 8;
    endcase
    keep = (nb == 8) ? ~64'h0 : ((64'h1 << (8 * nb)) - 64'h1);
    case (f)
      7'h57, 7'h67, 7'h77: return (a & keep) >> s;
      7'h5A, 7'h6A, 7'h7A: return (a << s) & keep;
      7'h52, 7'h62, 7'h72: begin
        r = a;
        for (int i = 0; i < 8; i++)
          if (i + 8 - o < nb) r[8*i +: 8] = 8'h00;
        return r;
      end
      default: return d;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] f);
    case (f)
      7'h57: return "R1 R5";
      7'h5A: return "R1 R6";
      7'h67: return "R2 R5";
      7'h6A: return "R2 R6";
      7'h77: return "R3 R5";
      7'h7A: return "R3 R6";
      7'h52, 7'h62, 7'h72: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] d, input string tag);
    logic [63:0] e;
    @(negedge clk);
    func = f; opa = a; opb = b; dst_in = d; in_valid = 1'b1;
    e = model(f, a, b, d);
    #1 check({tag, " R10 comb"}, res_comb, e);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 valid", {63'h0, out_valid}, 64'h1);
    check({tag, " R11 reg"}, out_res, e);
  endtask

  logic [6:0] codes [9] = '{7'h52, 7'h57, 7'h5A, 7'h62, 7'h67, 7'h6A, 7'h72, 7'h77, 7'h7A};
  logic [63:0] pats [4] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
                            64'h8000_0000_0000_0001, 64'hA5C3_1E7F_0FF0_5A96};
  logic [6:0] others [4] = '{7'h00, 7'h56, 7'h5B, 7'h7F};

  initial begin
    #5;
    check("R12 valid", {63'h0, out_valid}, 64'h0);
    check("R12 res", out_res, 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 9; c++)
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 8; o++)
          apply(codes[c], pats[p], 64'(o), 64'hDEAD_BEEF_0000_1111, tag_of(codes[c]));
    // R4: upper bits of B set must not change results
    for (int c = 0; c < 9; c++)
      for (int o = 0; o < 8; o++)
        apply(codes[c], pats[0], 64'hFFFF_FFFF_FFFF_FFF8 | 64'(o), 64'h0, "R4");
    // R8: mask-high at offset 0
    apply(7'h72, pats[3], 64'h0, 64'h0, "R8");
    check("R8 identity", res_comb, pats[3]);
    // R9: unlisted codes
    for (int k = 0; k < 4; k++)
      apply(others[k], pats[1], 64'h5, 64'h1357_9BDF_2468_ACE0, "R9");
    // R11: hold while in_valid low
    @(negedge clk);
    func = 7'h77; opa = pats[0]; opb = 64'h3; in_valid = 1'b0;
    @(negedge clk);
    check("R11 idle valid", {63'h0, out_valid}, 64'h0);
    check("R11 hold", out_res, 64'h1357_9BDF_2468_ACE0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule